// File: doc/BRIEF.md
# Start-Byte Framed Three-Wire Serial Slave

This block receives a clock-synchronous serial stream from a host and turns it into parallel register writes for a display controller core. The host supplies the shift clock (`sck`), the serial input (`sdi`) and an active-low select (`cs_n`). The block finds its framing inside the stream itself. A header byte opens a transfer. It holds a run of five ones, then a direction bit, a register-select bit and a mandatory zero.

In write direction, every 8-bit value arrives as two bytes. Each byte carries one nibble in its low half and zeros in its high half. The block joins the two nibbles. It then moves the value and its register-select flag into the core clock domain and announces it with a one-cycle strobe. Further pairs may follow without a new header for as long as direction and register select stay the same.

In read direction, the block shifts a byte supplied by the core out on `sdo`, repeating once per byte. A header pattern found at any byte boundary re-opens framing. A high `cs_n` throws away whatever was partly received. Padding that breaks the format raises a sticky error flag.

Top module: `ssp_slave`

## Requirements
- R1: After `rst`, `wr_stb`, `wr_rs`, `wr_data`, `frm_err` and `sdo` are all 0.
- R2: Bits are taken least significant first on rising `sck` edges. A header is five 1 bits, then the direction bit (0 = write, 1 = read), then the register-select bit, then one bit that must be 0.
- R3: In write direction, the first byte carries value bits 3:0 in its bit positions 3:0. The second byte carries value bits 7:4 in its positions 3:0. Positions 7:4 of each byte are 0. After the second byte, `wr_data` shows the value and `wr_rs` shows the header's register-select bit.
- R4: After one header, any number of further value pairs is accepted and strobed without a new header.
- R5: While `cs_n` is high, `sck` and `sdi` have no effect. Raising `cs_n` drops any partial byte or half pair and returns the block to header search.
- R6: Five 1 bits in positions 0 to 4 of a byte boundary during write or read re-open a header. Any half-received pair is discarded.
- R7: A header whose final bit is 1 sets `frm_err`, produces no value and returns to header search.
- R8: A data byte with a 1 in positions 7:4 sets `frm_err` and is discarded. The next good byte is taken as a low nibble.
- R9: `frm_err` stays set until `rst`.
- R10: In read direction, `rd_data` is sent least significant bit first on `sdo`, which changes on falling `sck` edges. `rd_data` is sampled again at each byte boundary. `sdo` is 0 outside read direction and while `cs_n` is high.
- R11: With `cs_n` held low from reset onward, headers and writes work using `sck` and `sdi` alone.
- R12: Each received value gives exactly one `wr_stb` pulse, one `clk` cycle long. `wr_data` and `wr_rs` hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; also clears the serial side |
| cs_n | input | 1 | Active-low select; high clears serial framing |
| sck | input | 1 | Host shift clock |
| sdi | input | 1 | Serial data from host |
| rd_data | input | 8 | Byte the core offers for read transfers |
| sdo | output | 1 | Serial data to host |
| wr_stb | output | 1 | One-cycle strobe per received value (core domain) |
| wr_rs | output | 1 | Register-select flag of the last value |
| wr_data | output | 8 | Last received value |
| frm_err | output | 1 | Sticky framing error |

## Verification
The hardest case to reach is a header that appears in the middle of a write stream, just after the first half of a pair. Only a correct reset of the pair state stops the stale low nibble from being joined with the next byte. The bench sends a lone low-nibble byte and follows it at once with a header of a different register select. It then checks that exactly one strobe arrives, carrying the new flag and the value from the fresh pair. A related case, a `cs_n` release between the two halves of a pair, is reached the same way. In that case `sck` keeps toggling with a valid-looking pattern while the select is high.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SYNC_LEN = 5;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int VAL_W    = 2 * NIB_W;
    localparam int IDX_W    = $clog2(BYTE_W);
    localparam int ONES_W   = $clog2(SYNC_LEN);

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_WR,
        ST_RD
    } link_st_e;

    typedef struct packed {
        logic             rs;
        logic [VAL_W-1:0] val;
    } wr_word_t;

    function automatic logic pad_clean(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:NIB_W] == '0;
    endfunction

endpackage

// File: rtl/ssp_frame.sv
module ssp_frame
    import ssp_pkg::*;
(
    input  logic              sck,
    input  logic              clr,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              emit,
    output wr_word_t          emit_word,
    output logic              bad,
    output logic              tx_bit
);

    localparam logic [IDX_W-1:0]  I_SYNC_END = IDX_W'(SYNC_LEN - 1);
    localparam logic [IDX_W-1:0]  I_RW       = IDX_W'(SYNC_LEN);
    localparam logic [IDX_W-1:0]  I_RS       = IDX_W'(SYNC_LEN + 1);
    localparam logic [IDX_W-1:0]  I_LAST     = IDX_W'(BYTE_W - 1);
    localparam logic [ONES_W-1:0] ONES_END   = ONES_W'(SYNC_LEN - 1);

    link_st_e          st, st_n;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [ONES_W-1:0] ones, ones_n;
    logic              run, run_n;
    logic [BYTE_W-1:0] sh, sh_n, byte_n;
    logic [NIB_W-1:0]  lo, lo_n;
    logic              half, half_n;
    logic              rw, rw_n;
    logic              rs, rs_n;
    logic [BYTE_W-1:0] tx, tx_n;

    always_comb begin
        st_n      = st;
        idx_n     = idx;
        ones_n    = ones;
        run_n     = run;
        sh_n      = sh;
        lo_n      = lo;
        half_n    = half;
        rw_n      = rw;
        rs_n      = rs;
        tx_n      = tx;
        emit      = 1'b0;
        bad       = 1'b0;
        emit_word = '0;
        byte_n    = {sdi, sh[BYTE_W-1:1]};
        case (st)
            ST_HUNT: begin
                if (sdi) begin
                    if (ones == ONES_END) begin
                        st_n   = ST_HDR;
                        idx_n  = I_RW;
                        ones_n = '0;
                    end else begin
                        ones_n = ones + 1'b1;
                    end
                end else begin
                    ones_n = '0;
                end
            end
            ST_HDR: begin
                idx_n = idx + 1'b1;
                if (idx == I_RW) begin
                    rw_n = sdi;
                end else if (idx == I_RS) begin
                    rs_n = sdi;
                end else begin
                    run_n  = 1'b1;
                    half_n = 1'b0;
                    if (sdi) begin
                        bad  = 1'b1;
                        st_n = ST_HUNT;
                    end else begin
                        st_n = rw ? ST_RD : ST_WR;
                        tx_n = rd_data;
                    end
                end
            end
            default: begin
                idx_n = idx + 1'b1;
                sh_n  = byte_n;
                run_n = run & sdi;
                if (idx == I_SYNC_END && run && sdi) begin
                    st_n  = ST_HDR;
                    idx_n = I_RW;
                end else if (idx == I_LAST) begin
                    run_n = 1'b1;
                    if (st == ST_RD) begin
                        tx_n = rd_data;
                    end else if (!pad_clean(byte_n)) begin
                        bad    = 1'b1;
                        half_n = 1'b0;
                    end else if (!half) begin
                        lo_n   = byte_n[NIB_W-1:0];
                        half_n = 1'b1;
                    end else begin
                        emit          = 1'b1;
                        emit_word.rs  = rs;
                        emit_word.val = {byte_n[NIB_W-1:0], lo};
                        half_n        = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge sck or posedge clr) begin
        if (clr) begin
            st   <= ST_HUNT;
            idx  <= '0;
            ones <= '0;
            run  <= 1'b1;
            sh   <= '0;
            lo   <= '0;
            half <= 1'b0;
            rw   <= 1'b0;
            rs   <= 1'b0;
            tx   <= '0;
        end else begin
            st   <= st_n;
            idx  <= idx_n;
            ones <= ones_n;
            run  <= run_n;
            sh   <= sh_n;
            lo   <= lo_n;
            half <= half_n;
            rw   <= rw_n;
            rs   <= rs_n;
            tx   <= tx_n;
        end
    end

    always_ff @(negedge sck or posedge clr) begin
        if (clr) begin
            tx_bit <= 1'b0;
        end else begin
            tx_bit <= (st == ST_RD) ? tx[idx] : 1'b0;
        end
    end

endmodule

// File: rtl/ssp_tgl_sync.sv
module ssp_tgl_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         rst,
    input  logic         src_ev,
    input  logic [W-1:0] src_pay,
    input  logic         dst_clk,
    output logic         dst_pulse,
    output logic [W-1:0] dst_pay
);

    logic         tgl;
    logic [W-1:0] hold;
    logic [STAGES:0] sync;
    logic         edge_seen;

    always_ff @(posedge src_clk or posedge rst) begin
        if (rst) begin
            tgl  <= 1'b0;
            hold <= '0;
        end else if (src_ev) begin
            tgl  <= ~tgl;
            hold <= src_pay;
        end
    end

    assign edge_seen = sync[STAGES] ^ sync[STAGES-1];

    always_ff @(posedge dst_clk) begin
        if (rst) begin
            sync      <= '0;
            dst_pulse <= 1'b0;
            dst_pay   <= '0;
        end else begin
            sync      <= {sync[STAGES-1:0], tgl};
            dst_pulse <= edge_seen;
            if (edge_seen) begin
                dst_pay <= hold;
            end
        end
    end

endmodule

// File: rtl/ssp_slave.sv
module ssp_slave
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sdo,
    output logic              wr_stb,
    output logic              wr_rs,
    output logic [VAL_W-1:0]  wr_data,
    output logic              frm_err
);

    localparam int WORD_W = $bits(wr_word_t);

    logic     ser_clr;
    logic     emit, bad;
    wr_word_t emit_word, core_word;
    logic     err_pulse;
    logic     err_pay;

    assign ser_clr = cs_n | rst;

    ssp_frame u_frame (
        .sck       (sck),
        .clr       (ser_clr),
        .sdi       (sdi),
        .rd_data   (rd_data),
        .emit      (emit),
        .emit_word (emit_word),
        .bad       (bad),
        .tx_bit    (sdo)
    );

    ssp_tgl_sync #(.W(WORD_W), .STAGES(2)) u_word_sync (
        .src_clk   (sck),
        .rst       (rst),
        .src_ev    (emit),
        .src_pay   (emit_word),
        .dst_clk   (clk),
        .dst_pulse (wr_stb),
        .dst_pay   (core_word)
    );

    ssp_tgl_sync #(.W(1), .STAGES(2)) u_err_sync (
        .src_clk   (sck),
        .rst       (rst),
        .src_ev    (bad),
        .src_pay   (1'b1),
        .dst_clk   (clk),
        .dst_pulse (err_pulse),
        .dst_pay   (err_pay)
    );

    assign wr_rs   = core_word.rs;
    assign wr_data = core_word.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_err <= 1'b0;
        end else if (err_pulse) begin
            frm_err <= 1'b1;
        end
    end

endmodule

// File: rtl/ssp_slave_chk.sv
module ssp_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sdo,
    input logic       wr_stb,
    input logic       wr_rs,
    input logic [7:0] wr_data,
    input logic       frm_err
);

    p_stb_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> ($stable(wr_data) && $stable(wr_rs)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        frm_err |=> frm_err);

    p_sdo_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sdo);

endmodule

bind ssp_slave ssp_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sdo     (sdo),
    .wr_stb  (wr_stb),
    .wr_rs   (wr_rs),
    .wr_data (wr_data),
    .frm_err (frm_err)
);

// File: tb/sim_ssp_slave.sv
`timescale 1ns/1ps
module sim_ssp_slave;

    localparam int HALF = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       sdo, wr_stb, wr_rs, frm_err;
    logic [7:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    logic [7:0] last_d = 8'h00;
    logic       last_rs = 1'b0;

    ssp_slave u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .rd_data(rd_data), .sdo(sdo), .wr_stb(wr_stb), .wr_rs(wr_rs),
        .wr_data(wr_data), .frm_err(frm_err)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_d  = wr_data;
            last_rs = wr_rs;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic so);
        sdi = b;
        #(HALF);
        so  = sdo;
        sck = 1'b1;
        #(HALF);
        sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] v);
        logic so;
        for (int i = 0; i < 8; i++) bit_x(v[i], so);
    endtask

    task automatic hdr_x(input logic rw, input logic rs, input logic zb);
        byte_x({zb, rs, rw, 5'b11111});
    endtask

    task automatic val_x(input logic [7:0] v);
        byte_x({4'h0, v[3:0]});
        byte_x({4'h0, v[7:4]});
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        #3;
    endtask

    task automatic expect_val(input int base, input logic [7:0] d, input logic rs, input string req);
        chk(stb_cnt == base + 1, {req, " strobe count"}, stb_cnt - base, 1);
        chk(last_d == d, {req, " data"}, last_d, d);
        chk(last_rs == rs, {req, " rs"}, last_rs, rs);
    endtask

    task automatic t_reset();
        chk(wr_stb == 0 && wr_data == 0 && wr_rs == 0, "R1 write outputs", {wr_stb, wr_rs, wr_data}, 0);
        chk(frm_err == 0 && sdo == 0, "R1 err/sdo", {frm_err, sdo}, 0);
    endtask

    task automatic t_tied_low_write();
        int base = stb_cnt;
        logic so;
        for (int i = 0; i < 3; i++) bit_x(1'b0, so);
        hdr_x(1'b0, 1'b0, 1'b0);
        val_x(8'hA5);
        settle();
        expect_val(base, 8'hA5, 1'b0, "R2 R3 R11");
    endtask

    task automatic t_continuous();
        int base = stb_cnt;
        val_x(8'h3C);
        settle();
        expect_val(base, 8'h3C, 1'b0, "R4 first");
        val_x(8'h81);
        settle();
        expect_val(base + 1, 8'h81, 1'b0, "R4 second");
    endtask

    task automatic t_resync();
        int base = stb_cnt;
        byte_x(8'h04);
        hdr_x(1'b0, 1'b1, 1'b0);
        val_x(8'h96);
        settle();
        expect_val(base, 8'h96, 1'b1, "R6");
    endtask

    task automatic t_cs_drop();
        int base = stb_cnt;
        logic so;
        hdr_x(1'b0, 1'b0, 1'b0);
        byte_x(8'h05);
        for (int i = 0; i < 3; i++) bit_x(1'b1, so);
        cs_n = 1'b1;
        hdr_x(1'b0, 1'b1, 1'b0);
        val_x(8'h77);
        settle();
        chk(stb_cnt == base, "R5 ignored while deselected", stb_cnt - base, 0);
        cs_n = 1'b0;
        hdr_x(1'b0, 1'b0, 1'b0);
        val_x(8'h12);
        settle();
        expect_val(base, 8'h12, 1'b0, "R5");
    endtask

    task automatic t_read();
        int base = stb_cnt;
        logic so;
        logic [7:0] got;
        rd_data = 8'hC3;
        hdr_x(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b0, so);
            got[i] = so;
            if (i == 0) rd_data = 8'h5A;
        end
        chk(got == 8'hC3, "R10 first read byte", got, 8'hC3);
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b0, so);
            got[i] = so;
        end
        chk(got == 8'h5A, "R10 resampled read byte", got, 8'h5A);
        cs_n = 1'b1;
        #50;
        chk(sdo == 1'b0, "R10 sdo low when deselected", sdo, 0);
        settle();
        chk(stb_cnt == base, "R10 no strobe on read", stb_cnt - base, 0);
        cs_n = 1'b0;
    endtask

    task automatic t_hdr_err();
        int base = stb_cnt;
        hdr_x(1'b0, 1'b0, 1'b1);
        val_x(8'h33);
        settle();
        chk(frm_err == 1'b1, "R7 flag", frm_err, 1);
        chk(stb_cnt == base, "R7 no value", stb_cnt - base, 0);
        hdr_x(1'b0, 1'b0, 1'b0);
        val_x(8'h44);
        settle();
        chk(frm_err == 1'b1, "R9 sticky", frm_err, 1);
    endtask

    task automatic t_pad_err();
        int base;
        @(posedge clk); #3;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        rst = 1'b0;
        settle();
        chk(frm_err == 1'b0, "R9 cleared by rst", frm_err, 0);
        base = stb_cnt;
        hdr_x(1'b0, 1'b1, 1'b0);
        byte_x(8'h15);
        settle();
        chk(frm_err == 1'b1, "R8 flag", frm_err, 1);
        val_x(8'h6B);
        settle();
        expect_val(base, 8'h6B, 1'b1, "R8 discard");
    endtask

    initial begin
        #3;
        repeat (5) @(posedge clk);
        #3;
        t_reset();
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        t_tied_low_write();
        t_continuous();
        t_resync();
        t_cs_drop();
        t_read();
        t_hdr_err();
        t_pad_err();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule